// File: doc/BRIEF.md
# Back-to-Back Inter-Frame Gap Timer

This block keeps the idle time between the end of one transmitted frame and the start of the next, when a 10 Mb/s nibble-wide transmitter sends frames back to back. The transmitter pulses `frame_done` when a frame ends. From that point the block counts nibble periods, marked by the clock enable `nib_en`. It raises `gap_ready` only once the programmed gap has elapsed. A request to send the next frame (`frame_req`) that arrives during the gap is stored. It is granted with a one-cycle `frame_go` pulse on the first nibble period after the gap ends.

The gap length is set by a 7-bit field. Its value is the desired gap in nibble times minus an offset that depends on the duplex mode: 3 in full duplex and 6 in half duplex. The setting 0x15 in full duplex and the setting 0x12 in half duplex both give the standard minimum gap of 24 nibble times (9.6 µs). The field value and the duplex flag are captured when a frame ends, so changing either one during a gap does not alter that gap.

Top module: `ipg_b2b_timer`

## Requirements
- R1: After reset the gap field reads 0, `gap_ready` is 1, and `frame_go` is 0 while no request is made.
- R2: A write with `cfg_we` high stores `cfg_wdata[6:0]`. `cfg_rdata[6:0]` returns the stored field and `cfg_rdata[7]` always reads 0.
- R3: With `full_duplex`=1 at `frame_done`, the gap is L = field+3 nibble periods. `gap_ready` is 0 from the cycle after `frame_done` until L `nib_en` cycles have followed it. A pending request is granted on the (L+1)-th `nib_en` cycle after `frame_done`.
- R4: With `full_duplex`=0 at `frame_done`, L = field+6, with the same timing as R3.
- R5: The gap count moves only in cycles with `nib_en`=1. Without it, `gap_ready` stays 0 indefinitely during a gap.
- R6: Writing the field or toggling `full_duplex` during a gap does not change the length of that gap.
- R7: A `frame_req` pulse during a gap is held and produces exactly one `frame_go` pulse, in the first cycle where `nib_en`=1 and `gap_ready`=1.
- R8: When `gap_ready`=1, a `frame_req` in a cycle with `nib_en`=1 is granted in that same cycle. With `nib_en`=0 it is granted in the next `nib_en` cycle.
- R9: `frame_go` is 0 in any cycle where `frame_done`=1. A request made in such a cycle is held until the new gap ends.
- R10: Without `frame_done`, `gap_ready` stays 1 once the gap has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nib_en | input | 1 | One-cycle enable per nibble period |
| frame_done | input | 1 | Pulse at the end of a transmitted frame |
| frame_req | input | 1 | Pulse requesting the next frame |
| frame_go | output | 1 | Grant pulse allowing the next frame to start |
| gap_ready | output | 1 | High when no gap is in progress |
| full_duplex | input | 1 | 1 = full duplex offset (+3), 0 = half duplex offset (+6) |
| cfg_we | input | 1 | Gap field write strobe |
| cfg_wdata | input | 8 | Gap field write data (bit 7 ignored) |
| cfg_rdata | output | 8 | Gap field read data (bit 7 is 0) |

## Verification
The hardest situation to reach is a request that waits through a gap in which nibble enables arrive irregularly, while the settings change in the middle of that gap. A grant that is off by one cycle only shows up when the enable pattern is not every cycle. The random trials therefore draw a sparse, random `nib_en` pattern, rewrite the field and flip the duplex flag during the gap, and count enables from `frame_done` to `frame_go` against L+1. Directed cases cover grants while idle, a request made together with `frame_done`, and long stalls with no enable.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
  localparam int unsigned GAP_W  = 7;
  localparam int unsigned CNT_W  = GAP_W + 1;
  localparam int unsigned REG_W  = GAP_W + 1;
  localparam int unsigned FD_OFS = 3;
  localparam int unsigned HD_OFS = 6;

  typedef enum logic {
    DPX_HALF = 1'b0,
    DPX_FULL = 1'b1
  } duplex_e;
endpackage

// File: rtl/ipg_gap_cfg.sv
module ipg_gap_cfg #(
  parameter int unsigned GAP_W = ipg_pkg::GAP_W,
  localparam int unsigned REG_W = GAP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [GAP_W-1:0] gap
);
  logic [GAP_W-1:0] gap_q, gap_d;

  always_comb begin
    gap_d = gap_q;
    if (we) gap_d = wdata[GAP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else        gap_q <= gap_d;
  end

  assign gap   = gap_q;
  assign rdata = {1'b0, gap_q};

  // R2: top bit never reads as one
  always_comb begin
    if (rst_n) p_top_bit_zero_r2: assert (rdata[REG_W-1] == 1'b0);
  end

  // R2: a write is visible on the next cycle
  p_write_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rdata[GAP_W-1:0] == $past(wdata[GAP_W-1:0]));
endmodule

// File: rtl/ipg_gap_counter.sv
module ipg_gap_counter #(
  parameter int unsigned GAP_W  = ipg_pkg::GAP_W,
  parameter int unsigned FD_OFS = ipg_pkg::FD_OFS,
  parameter int unsigned HD_OFS = ipg_pkg::HD_OFS,
  localparam int unsigned CNT_W = GAP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nib_en,
  input  logic             frame_done,
  input  logic             full_duplex,
  input  logic [GAP_W-1:0] gap,
  output logic             ready
);
  import ipg_pkg::*;

  localparam logic [CNT_W-1:0] FD_ADD = CNT_W'(FD_OFS);
  localparam logic [CNT_W-1:0] HD_ADD = CNT_W'(HD_OFS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] offset;
  logic [CNT_W-1:0] load_val;
  logic             cnt_zero;
  duplex_e          dpx;

  assign dpx      = duplex_e'(full_duplex);
  assign offset   = (dpx == DPX_FULL) ? FD_ADD : HD_ADD;
  assign load_val = {1'b0, gap} + offset;
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (frame_done)             cnt_d = load_val;
    else if (nib_en && !cnt_zero) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready = cnt_zero;

  // R3 R4: a frame end always opens a gap of at least three periods
  p_gap_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !ready);

  // R5: without an enable the count does not move
  p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!nib_en && !frame_done) |=> $stable(cnt_q));

  // R10: ready holds until the next frame end
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !frame_done) |=> ready);

  // R5: the count never wraps below zero
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero && !frame_done) |=> cnt_zero);
endmodule

// File: rtl/ipg_grant_ctl.sv
module ipg_grant_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic nib_en,
  input  logic frame_done,
  input  logic frame_req,
  input  logic ready,
  output logic frame_go
);
  logic pend_q, pend_d;
  logic want;

  assign want     = frame_req | pend_q;
  assign frame_go = want & ready & nib_en & ~frame_done;

  always_comb begin
    pend_d = pend_q;
    if (frame_go)       pend_d = 1'b0;
    else if (frame_req) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  // R9: never grant while a frame is ending
  p_no_go_on_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !frame_go);

  // R7: grant only when the gap is over, on a nibble period
  p_go_qualified_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go |-> (ready && nib_en));

  // R7: one grant per request, no second pulse without a new request
  p_single_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_go && !frame_req) |=> !frame_go || $past(frame_req) == 1'b0 && frame_req);

  // R7: a held request is not dropped before its grant
  p_pend_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !frame_go) |=> pend_q);
endmodule

// File: rtl/ipg_b2b_timer.sv
module ipg_b2b_timer #(
  parameter int unsigned GAP_W       = ipg_pkg::GAP_W,
  parameter int unsigned FD_OFS      = ipg_pkg::FD_OFS,
  parameter int unsigned HD_OFS      = ipg_pkg::HD_OFS,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned REG_W      = GAP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nib_en,
  input  logic             frame_done,
  input  logic             frame_req,
  output logic             frame_go,
  output logic             gap_ready,
  input  logic             full_duplex,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_i;
  logic [GAP_W-1:0]       gap;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign rst_n_i  = rst_n;
      assign rst_pipe = '0;
    end else begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_n_i = rst_pipe[SYNC_STAGES-1];
    end
  endgenerate

  ipg_gap_cfg #(.GAP_W(GAP_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n_i),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .gap   (gap)
  );

  ipg_gap_counter #(.GAP_W(GAP_W), .FD_OFS(FD_OFS), .HD_OFS(HD_OFS)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .nib_en      (nib_en),
    .frame_done  (frame_done),
    .full_duplex (full_duplex),
    .gap         (gap),
    .ready       (gap_ready)
  );

  ipg_grant_ctl u_grant (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .nib_en     (nib_en),
    .frame_done (frame_done),
    .frame_req  (frame_req),
    .ready      (gap_ready),
    .frame_go   (frame_go)
  );

  // R1: out of reset the timer is idle
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(rst_n_i) |-> gap_ready);
endmodule

// File: tb/ipg_b2b_timer_bench.sv
module ipg_b2b_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       nib_en, frame_done, frame_req, full_duplex, cfg_we;
  logic [7:0] cfg_wdata;
  logic       frame_go, gap_ready;
  logic [7:0] cfg_rdata;

  int checks = 0;
  int errors = 0;
  logic o_go, o_rdy;
  logic [7:0] o_rd;

  always #4 clk = ~clk;

  ipg_b2b_timer u_ipg_b2b_timer (
    .clk(clk), .rst_n(rst_n), .nib_en(nib_en), .frame_done(frame_done),
    .frame_req(frame_req), .frame_go(frame_go), .gap_ready(gap_ready),
    .full_duplex(full_duplex), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata)
  );

  function automatic int gap_len(input int field, input bit fd);
    return (field & 8'h7f) + (fd ? 3 : 6);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive after the falling edge, sample 2 ns later, then pass the rising edge
  task automatic cyc(input bit nib, input bit done, input bit req,
                     input bit we = 1'b0, input logic [7:0] wd = 8'h00);
    @(negedge clk);
    nib_en = nib; frame_done = done; frame_req = req;
    cfg_we = we; cfg_wdata = wd;
    #2;
    o_go = frame_go; o_rdy = gap_ready; o_rd = cfg_rdata;
    @(posedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, v);
  endtask

  // run a full gap with a request issued right after the end; count enables
  task automatic gap_run(input string req, input int field, input bit fd,
                         input int nib_pct, input bit disturb);
    int exp_l, nibs, go_at, bad_rdy, gos;
    bit n;
    exp_l = gap_len(field, fd);
    full_duplex = fd;
    wr(field[7:0]);
    cyc(1'b0, 1'b1, 1'b0);
    nibs = 0; go_at = -1; bad_rdy = 0; gos = 0;
    for (int k = 1; k < 3000; k++) begin
      n = ($urandom % 100) < nib_pct;
      if (disturb && k == 2) begin
        full_duplex = ~fd;
        cyc(n, 1'b0, 1'b0, 1'b1, 8'($urandom));
      end else begin
        cyc(n, 1'b0, (k == 1));
      end
      if (o_rdy != (nibs >= exp_l)) bad_rdy++;
      if (n) nibs++;
      if (o_go) begin
        gos++;
        if (go_at < 0) go_at = nibs;
      end
      if (go_at >= 0 && nibs > go_at + 3) break;
    end
    chk({req, " grant enable index"}, go_at, exp_l + 1);
    chk({req, " ready timing"}, bad_rdy, 0);
    chk("R7 single grant", gos, 1);
    full_duplex = fd;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; nib_en = 0; frame_done = 0; frame_req = 0;
    full_duplex = 1; cfg_we = 0; cfg_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    cyc(1'b1, 1'b0, 1'b0);
    chk("R1 field", o_rd, 0);
    chk("R1 ready", o_rdy, 1);
    chk("R1 no grant", o_go, 0);

    // R2 bit 7 ignored
    wr(8'hff);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R2 readback", o_rd, 8'h7f);
    wr(8'h2a);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R2 readback", o_rd, 8'h2a);

    // R3 / R4 recommended settings, enable every cycle: 24 periods
    gap_run("R3", 8'h15, 1'b1, 100, 1'b0);
    gap_run("R4", 8'h12, 1'b0, 100, 1'b0);
    gap_run("R3", 0, 1'b1, 100, 1'b0);
    gap_run("R4", 127, 1'b0, 100, 1'b0);

    // R5 long stall with no enables
    full_duplex = 1; wr(8'h00);
    cyc(1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 40; k++) cyc(1'b0, 1'b0, 1'b0);
    chk("R5 stalled ready", o_rdy, 0);
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R5 ready after 3 enables", o_rdy, 1);

    // R8 idle request granted immediately on an enable cycle
    cyc(1'b1, 1'b0, 1'b1);
    chk("R8 same-cycle grant", o_go, 1);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R8 no grant without enable", o_go, 0);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R8 still waiting", o_go, 0);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R8 grant on next enable", o_go, 1);

    // R10 ready stays high with enables and no frame end
    for (int k = 0; k < 50; k++) cyc(1'b1, 1'b0, 1'b0);
    chk("R10 idle ready", o_rdy, 1);
    chk("R10 no stray grant", o_go, 0);

    // R9 request together with frame end: held until gap ends (L=3)
    cyc(1'b1, 1'b1, 1'b1);
    chk("R9 no grant on end", o_go, 0);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R9 ready dropped", o_rdy, 0);
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R9 not yet", o_go, 0);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R9 held request granted", o_go, 1);

    // R6 directed: mid-gap changes ignored
    gap_run("R6", 8'h15, 1'b1, 100, 1'b1);
    gap_run("R6", 8'h12, 1'b0, 50, 1'b1);

    // random trials, sparse enables, with and without disturbance (R6 R7)
    for (int t = 0; t < 40; t++) begin
      int f;
      bit d, x;
      f = $urandom % 128;
      d = $urandom % 2;
      x = $urandom % 2;
      gap_run(x ? "R6" : (d ? "R3" : "R4"), f, d, 20 + ($urandom % 80), x);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule